// File: doc/BRIEF.md
# Interleaved Address Decoder with Port Selection

This block steers a host physical address to one of several downstream ports. Software programs up to four range decoders through a 32-bit register port. Each decoder holds a 64-bit base, a 64-bit size, a control word with granularity and way encodings, and a byte-packed table of eight 8-bit port IDs.

A lookup request presents an address. The decoders are searched in index order, up to a software-set limit. The first decoder whose window holds the address decides the result. If that decoder is committed, the block reports a hit. The address bits above the granularity shift pick an entry in that decoder's port table. The result is registered and appears one cycle after the request.

Commit and uncommit are write actions on the control word. The committed status bit can change only through those actions.

Top module: `ilv_target_sel`

Register map, as byte offsets:
- 0x00: search count in bits [2:0].
- 0x10 + 0x20·i: decoder i.

Word offsets inside a decoder block:

| Offset | Word |
|---|---|
| +0x00 | base low |
| +0x04 | base high |
| +0x08 | size low |
| +0x0C | size high |
| +0x10 | control |
| +0x14 | port table low |
| +0x18 | port table high |

Control word bit fields:

| Bits | Field |
|---|---|
| [3:0] | IG |
| [7:4] | IW |
| [9] | COMMIT |
| [10] | COMMITTED (read-only) |
| [11] | ERR |

## Requirements
- R1: After reset, rsp_valid_o is 0, every control word reads 0, and the search count reads 4.
- R2: Bits [27:0] of base low and size low are not stored; they read back as 0, so windows are 256 MB aligned.
- R3: A decoder claims an address when base <= addr < base + size. Addresses just below a window or at its end are not claimed.
- R4: When windows overlap, the lowest-index claiming decoder decides the result.
- R5: If the deciding decoder is not committed, the response is a miss, and higher-index decoders are not consulted.
- R6: Only decoders with index below the search count (register 0x00 bits [2:0]) are searched.
- R7: The table index is (addr >> (8 + IG)) modulo 2^IW.
- R8: Indices 0..3 select bytes 0..3 of port table low. Indices 4..7 select bytes 0..3 of port table high.
- R9: Writing a control word with COMMIT=1 and valid encodings (IG <= 6, IW <= 3) sets COMMITTED and clears ERR. Writing it with COMMIT=0 clears both COMMITTED and ERR.
- R10: A write to bit 10 of a control word is ignored. COMMITTED follows only the COMMIT bit of the written value.
- R11: Writing COMMIT=1 with IG > 6 or IW > 3 leaves COMMITTED at 0 and sets ERR to 1.
- R12: Each request produces exactly one response on the next clock edge. rsp_hit_o is 1 only while rsp_valid_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| req_valid_i | input | 1 | Lookup request |
| req_addr_i | input | 64 | Host physical address |
| rsp_valid_o | output | 1 | Lookup response valid |
| rsp_hit_o | output | 1 | Committed decoder claimed the address |
| rsp_port_o | output | 8 | Selected port ID |

## Verification
The commit assertions assume that a control write happens only through reg_we_i with a word-aligned offset. They also assume that reg_addr_i is stable while the strobe is high. The bench drives every write and every request half a cycle before the sampling edge and keeps the strobe high for exactly one edge. Requests are held low throughout reset, so the one-cycle response assertion never sees a request that the reset swallowed. Windows are programmed so that base plus size never wraps past 2^64, which is the case in which the range compare is defined.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int unsigned ADDR_W  = 64;
  localparam int unsigned PORT_W  = 8;
  localparam int unsigned TBL_N   = 8;
  localparam int unsigned IG_MAX  = 6;
  localparam int unsigned IW_MAX  = 3;
  localparam int unsigned GRAN_SH = 28;

  // word offsets inside a decoder block
  localparam logic [4:0] OFF_BASE_LO = 5'h00;
  localparam logic [4:0] OFF_BASE_HI = 5'h04;
  localparam logic [4:0] OFF_SIZE_LO = 5'h08;
  localparam logic [4:0] OFF_SIZE_HI = 5'h0C;
  localparam logic [4:0] OFF_CTRL    = 5'h10;
  localparam logic [4:0] OFF_TBL_LO  = 5'h14;
  localparam logic [4:0] OFF_TBL_HI  = 5'h18;

  localparam int unsigned B_COMMIT    = 9;
  localparam int unsigned B_COMMITTED = 10;
  localparam int unsigned B_ERR       = 11;

  typedef struct packed {
    logic [ADDR_W-1:0]       base;
    logic [ADDR_W-1:0]       size;
    logic [3:0]              ig;
    logic [3:0]              iw;
    logic                    commit;
    logic                    committed;
    logic                    err;
    logic [TBL_N*PORT_W-1:0] tbl;
  } dec_cfg_t;
endpackage

// File: rtl/ilv_dec_regs.sv
module ilv_dec_regs
  import ilv_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [4:0]  off_i,
  input  logic [31:0] wdata_i,
  output dec_cfg_t    cfg_o,
  output logic [31:0] rdata_o
);
  localparam int unsigned HI_W = ADDR_W - 32;

  logic [31:GRAN_SH] base_lo_q, size_lo_q;
  logic [HI_W-1:0]   base_hi_q, size_hi_q;
  logic [3:0]        ig_q, iw_q;
  logic              commit_q, committed_q, err_q;
  logic [31:0]       tbl_lo_q, tbl_hi_q;
  logic              ctrl_we, enc_ok;

  assign ctrl_we = we_i && (off_i == OFF_CTRL);
  assign enc_ok  = (wdata_i[3:0] <= 4'(IG_MAX)) && (wdata_i[7:4] <= 4'(IW_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_lo_q <= '0; base_hi_q <= '0;
      size_lo_q <= '0; size_hi_q <= '0;
      ig_q <= '0; iw_q <= '0;
      commit_q <= 1'b0; committed_q <= 1'b0; err_q <= 1'b0;
      tbl_lo_q <= '0; tbl_hi_q <= '0;
    end else if (we_i) begin
      unique case (off_i)
        OFF_BASE_LO: base_lo_q <= wdata_i[31:GRAN_SH];
        OFF_BASE_HI: base_hi_q <= wdata_i[HI_W-1:0];
        OFF_SIZE_LO: size_lo_q <= wdata_i[31:GRAN_SH];
        OFF_SIZE_HI: size_hi_q <= wdata_i[HI_W-1:0];
        OFF_CTRL: begin
          ig_q     <= wdata_i[3:0];
          iw_q     <= wdata_i[7:4];
          commit_q <= wdata_i[B_COMMIT];
          // COMMITTED is never written directly
          committed_q <= wdata_i[B_COMMIT] && enc_ok;
          err_q       <= wdata_i[B_COMMIT] && !enc_ok;
        end
        OFF_TBL_LO: tbl_lo_q <= wdata_i;
        OFF_TBL_HI: tbl_hi_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_o.base      = {base_hi_q, base_lo_q, {GRAN_SH{1'b0}}};
    cfg_o.size      = {size_hi_q, size_lo_q, {GRAN_SH{1'b0}}};
    cfg_o.ig        = ig_q;
    cfg_o.iw        = iw_q;
    cfg_o.commit    = commit_q;
    cfg_o.committed = committed_q;
    cfg_o.err       = err_q;
    cfg_o.tbl       = {tbl_hi_q, tbl_lo_q};
  end

  always_comb begin
    unique case (off_i)
      OFF_BASE_LO: rdata_o = {base_lo_q, {GRAN_SH{1'b0}}};
      OFF_BASE_HI: rdata_o = base_hi_q;
      OFF_SIZE_LO: rdata_o = {size_lo_q, {GRAN_SH{1'b0}}};
      OFF_SIZE_HI: rdata_o = size_hi_q;
      OFF_CTRL:    rdata_o = {20'b0, err_q, committed_q, commit_q, 1'b0, iw_q, ig_q};
      OFF_TBL_LO:  rdata_o = tbl_lo_q;
      OFF_TBL_HI:  rdata_o = tbl_hi_q;
      default:     rdata_o = '0;
    endcase
  end

  p_commit_only_by_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(committed_q) |-> $past(ctrl_we && wdata_i[B_COMMIT]));
  p_commit_ok_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && wdata_i[B_COMMIT] && enc_ok) |=> (committed_q && !err_q));
  p_uncommit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && !wdata_i[B_COMMIT]) |=> (!committed_q && !err_q));
  p_bad_enc_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && wdata_i[B_COMMIT] && !enc_ok) |=> (!committed_q && err_q));
endmodule

// File: rtl/ilv_dec_match.sv
module ilv_dec_match
  import ilv_pkg::*;
(
  input  dec_cfg_t          cfg_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              claim_o,
  output logic [PORT_W-1:0] port_o
);
  localparam int unsigned IDX_W = $clog2(TBL_N);

  logic [ADDR_W-1:0] offs, shifted;
  logic [IDX_W-1:0]  idx, mask;

  assign offs    = addr_i - cfg_i.base;
  assign claim_o = (addr_i >= cfg_i.base) && (offs < cfg_i.size);

  // granule = 256 << IG; index = granule number mod 2^IW
  assign shifted = addr_i >> (5'd8 + 5'(cfg_i.ig));
  assign mask    = IDX_W'((TBL_N - 1) >> (IW_MAX - ((cfg_i.iw > 4'(IW_MAX)) ? IW_MAX : int'(cfg_i.iw))));
  assign idx     = shifted[IDX_W-1:0] & mask;
  assign port_o  = cfg_i.tbl[idx*PORT_W +: PORT_W];
endmodule

// File: rtl/ilv_target_sel.sv
module ilv_target_sel
  import ilv_pkg::*;
#(
  parameter int unsigned NUM_DEC = 4,
  parameter int unsigned REG_AW  = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        req_valid_i,
  input  logic [63:0] req_addr_i,
  output logic        rsp_valid_o,
  output logic        rsp_hit_o,
  output logic [7:0]  rsp_port_o
);
  localparam int unsigned CNT_W    = $clog2(NUM_DEC + 1);
  localparam int unsigned DEC_BASE = 'h10;
  localparam int unsigned STRIDE   = 'h20;
  localparam int unsigned SEL_W    = REG_AW - 5;

  logic [CNT_W-1:0]  cnt_q;
  dec_cfg_t          cfg   [NUM_DEC];
  logic [31:0]       rdata [NUM_DEC];
  logic [NUM_DEC-1:0] claim;
  logic [PORT_W-1:0] port  [NUM_DEC];
  logic [REG_AW-1:0] rel;
  logic [SEL_W-1:0]  dsel;
  logic              in_dec;

  assign in_dec = reg_addr_i >= REG_AW'(DEC_BASE);
  assign rel    = reg_addr_i - REG_AW'(DEC_BASE);
  assign dsel   = rel[REG_AW-1:5];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CNT_W'(NUM_DEC);
    else if (reg_we_i && reg_addr_i == '0) cnt_q <= reg_wdata_i[CNT_W-1:0];
  end

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
    logic hit_sel;
    assign hit_sel = in_dec && (dsel == SEL_W'(g));
    ilv_dec_regs u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (reg_we_i && hit_sel),
      .off_i   (rel[4:0]),
      .wdata_i (reg_wdata_i),
      .cfg_o   (cfg[g]),
      .rdata_o (rdata[g])
    );
    ilv_dec_match u_match (
      .cfg_i   (cfg[g]),
      .addr_i  (req_addr_i),
      .claim_o (claim[g]),
      .port_o  (port[g])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == '0) reg_rdata_o = 32'(cnt_q);
    for (int i = 0; i < NUM_DEC; i++)
      if (in_dec && dsel == SEL_W'(i)) reg_rdata_o = rdata[i];
  end

  // first claiming decoder in index order decides
  logic              pick_hit;
  logic [PORT_W-1:0] pick_port;
  always_comb begin
    logic found;
    found     = 1'b0;
    pick_hit  = 1'b0;
    pick_port = '0;
    for (int i = 0; i < NUM_DEC; i++) begin
      if (!found && (CNT_W'(i) < cnt_q) && claim[i]) begin
        found     = 1'b1;
        pick_hit  = cfg[i].committed;
        pick_port = cfg[i].committed ? port[i] : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_port_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_hit_o   <= req_valid_i && pick_hit;
      rsp_port_o  <= req_valid_i ? pick_port : '0;
    end
  end

  p_rsp_follows_req_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_no_spurious_rsp_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  p_hit_in_rsp_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_valid_o);
endmodule

// File: tb/ilv_target_sel_test.sv
`timescale 1ns/1ps
module ilv_target_sel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  raddr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req = 1'b0;
  logic [63:0] addr = '0;
  logic        rv, rh;
  logic [7:0]  rp;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ilv_target_sel uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(raddr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .req_valid_i(req),
    .req_addr_i(addr), .rsp_valid_o(rv), .rsp_hit_o(rh), .rsp_port_o(rp)
  );

  function automatic logic [7:0] dreg(int d, int off);
    return 8'(16 + 32 * d + off);
  endfunction

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; raddr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(string r, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); raddr = a; #1;
    chk(r, rdata, exp);
  endtask

  task automatic look(string r, logic [63:0] a, logic exp_hit, logic [7:0] exp_port);
    @(negedge clk); req = 1'b1; addr = a;
    @(negedge clk); req = 1'b0;
    chk({r, " valid"}, rv, 1'b1);
    chk({r, " hit"}, rh, exp_hit);
    if (exp_hit) chk({r, " port"}, rp, exp_port);
    @(negedge clk);
    chk({r, " single"}, rv, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid", rv, 1'b0);
    rd_chk("R1 count", 8'h00, 32'd4);
    for (int d = 0; d < 4; d++) rd_chk("R1 ctrl", dreg(d, 'h10), 32'h0);
  endtask

  task automatic t_program;
    wr(dreg(0, 'h04), 32'h1);  wr(dreg(0, 'h08), 32'h4000_0000);
    wr(dreg(0, 'h14), 32'h1312_1110); wr(dreg(0, 'h18), 32'h1716_1514);
    wr(dreg(0, 'h10), 32'h220);
    rd_chk("R9 commit", dreg(0, 'h10), 32'h620);
    wr(dreg(1, 'h04), 32'h2);  wr(dreg(1, 'h0C), 32'h1);
    wr(dreg(1, 'h14), 32'h2322_2120); wr(dreg(1, 'h18), 32'h2726_2524);
    wr(dreg(1, 'h10), 32'h232);
  endtask

  task automatic t_align;
    wr(dreg(2, 'h00), 32'h1FFF_FFFF);
    rd_chk("R2 base lo", dreg(2, 'h00), 32'h1000_0000);
    wr(dreg(2, 'h08), 32'h1FFF_FFFF);
    rd_chk("R2 size lo", dreg(2, 'h08), 32'h1000_0000);
    wr(dreg(2, 'h00), 32'h0);  wr(dreg(2, 'h04), 32'h1);
    wr(dreg(2, 'h14), 32'hAA); wr(dreg(2, 'h10), 32'h200);
  endtask

  task automatic t_index;
    look("R7 idx0", 64'h1_0000_0000, 1, 8'h10);
    look("R7 idx3", 64'h1_0000_0300, 1, 8'h13);
    look("R7 wrap", 64'h1_0000_0500, 1, 8'h11);
    look("R8 hi byte1", 64'h2_0000_1400, 1, 8'h25);
    look("R8 hi byte3", 64'h2_0000_1C00, 1, 8'h27);
    look("R8 lo byte1", 64'h2_0000_0400, 1, 8'h21);
  endtask

  task automatic t_range;
    look("R3 last", 64'h1_3FFF_FFFF, 1, 8'h13);
    look("R3 end", 64'h1_4000_0000, 0, 8'h0);
    look("R3 below", 64'h0_FFFF_FFFF, 0, 8'h0);
  endtask

  task automatic t_prio;
    look("R4 overlap", 64'h1_0000_0300, 1, 8'h13);
    wr(dreg(0, 'h10), 32'h020);
    look("R5 no fallthrough", 64'h1_0000_0300, 0, 8'h0);
    wr(dreg(0, 'h10), 32'h220);
    look("R5 recommit", 64'h1_0000_0300, 1, 8'h13);
  endtask

  task automatic t_count;
    wr(8'h00, 32'd1);
    look("R6 limited", 64'h2_0000_1400, 0, 8'h0);
    look("R6 dec0 ok", 64'h1_0000_0000, 1, 8'h10);
    wr(8'h00, 32'd4);
    look("R6 restored", 64'h2_0000_1400, 1, 8'h25);
  endtask

  task automatic t_ctrl;
    wr(dreg(3, 'h10), 32'h207);
    rd_chk("R11 bad ig", dreg(3, 'h10), 32'hA07);
    wr(dreg(3, 'h10), 32'h240);
    rd_chk("R11 bad iw", dreg(3, 'h10), 32'hA40);
    wr(dreg(3, 'h10), 32'h200);
    rd_chk("R9 err cleared", dreg(3, 'h10), 32'h600);
    wr(dreg(3, 'h10), 32'h000);
    rd_chk("R9 uncommit", dreg(3, 'h10), 32'h000);
    wr(dreg(3, 'h10), 32'h400);
    rd_chk("R10 ro bit", dreg(3, 'h10), 32'h000);
    wr(dreg(1, 'h10), 32'h432);
    look("R10 uncommitted miss", 64'h2_0000_1400, 0, 8'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_program();
    t_align();
    t_index();
    t_range();
    t_prio();
    t_count();
    t_ctrl();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule